// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the slave side of an SPI byte memory. A host selects it with an active-low chip select and shifts in one command byte per frame. Six commands are understood: set the write-enable latch, clear it, read the status byte, write the status byte, read memory and write memory. Memory commands carry a two-byte address. After the address, bytes stream in or out while an internal address counter advances by one per byte.

Writes take effect at bus speed. Each received data byte goes into the array in the system-clock cycle after its eighth bit is sampled, so no busy state is ever reported. The serial pins are oversampled in the system clock domain. SPI modes 0 and 3 are handled alike: bits are taken on SCK rising edges and the output changes on SCK falling edges. A hold input pauses a frame without losing its state. The write-enable latch and the status bits sit in a separate status unit, which the engine drives with single-cycle command strobes.

The array is an inferred single-port RAM whose depth is set by a parameter. The default of 11 address bits keeps elaboration small. Setting it to 15 gives 32768 bytes.

Top module: `spi_mem_slave`

## Requirements
- R1: The first byte after chip select falls is decoded as the command, MSB first: 0x06 sets the latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads memory and 0x02 writes memory. Any other value, and every later byte of that frame, is ignored until chip select rises.
- R2: Bits are sampled on SCK rising edges and `miso` changes only after SCK falling edges. This holds in mode 0 (clock idles low) and in mode 3 (clock idles high), with the first bit taken on the first rising edge after chip select falls.
- R3: The status byte shows the write-enable latch in bit 1. Command 0x06 sets it and 0x04 clears it. Command 0x05 shifts the status byte out, and repeats it for as long as the host keeps clocking.
- R4: Command 0x01 followed by one byte stores bits 7, 3 and 2 of that byte into status, but only when the latch is set. Status bits 6, 5, 4 and 0 always read 0.
- R5: Command 0x02 takes a high address byte and then a low address byte. Address bits above the array width are ignored. Each full data byte is stored when the latch is set and dropped when it is clear. The address advances after every data byte in either case.
- R6: Command 0x03 takes the same two address bytes and then returns bytes from consecutive addresses, MSB first.
- R7: During streaming reads and writes, the address counter wraps from the top address to 0.
- R8: A frame whose command byte was 0x01 or 0x02 clears the latch when chip select rises.
- R9: The bits of an incomplete data byte are discarded when chip select rises.
- R10: While `hold_n` is low, SCK edges and chip-select changes are ignored and `miso_oe` is low. When `hold_n` goes high again, the frame resumes where it stopped.
- R11: `miso_oe` is high only while status or memory data is being shifted out. It is low after reset and within three clocks of chip select going high.
- R12: After a 0x06 or 0x04 command, further bytes in the same frame, including other command values, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run at least 8 times faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause of the current frame |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |

## Verification
Two actions can fall on the same system clock. The commit of a write byte happens in the cycle where the address counter rolls over from the top location to zero. The bench provokes this with a three-byte write that starts two bytes below the top, using an address whose ignored upper bits are set. It then reads back across the boundary. A second overlap is a chip-select pulse inside a hold window, sent while the hold also blocks SCK edges. Its effect is judged by whether the held write and read frames still deliver the scoreboard's expected bytes.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] CMD_LATCH_SET = 8'h06;
  localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD   = 8'h05;
  localparam logic [7:0] CMD_STAT_WR   = 8'h01;
  localparam logic [7:0] CMD_MEM_RD    = 8'h03;
  localparam logic [7:0] CMD_MEM_WR    = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_MWR,
    PH_MRD,
    PH_SWR,
    PH_SRD,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    ST_NOP,
    ST_SET,
    ST_CLR,
    ST_WR
  } st_cmd_t;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int SYNC_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_hi,
  output logic hold_ok,
  output logic mosi_s
);
  // lane order {mosi, hold_n, cs_n, sck}
  localparam logic [3:0] IDLE_V = 4'b0110;

  logic [SYNC_W-1:0][3:0] pipe_q;
  logic                   sck_prev_q;
  logic [3:0]             cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q     <= {SYNC_W{IDLE_V}};
      sck_prev_q <= 1'b0;
    end else begin
      pipe_q     <= {pipe_q[SYNC_W-2:0], {mosi, hold_n, cs_n, sck}};
      sck_prev_q <= cur[0];
    end
  end

  assign cur      = pipe_q[SYNC_W-1];
  assign sck_rise = cur[0] & ~sck_prev_q;
  assign sck_fall = ~cur[0] & sck_prev_q;
  assign cs_hi    = cur[1];
  assign hold_ok  = cur[2];
  assign mosi_s   = cur[3];

endmodule

// File: rtl/spi_mem_status.sv
module spi_mem_status
  import spi_mem_pkg::*;
#(
  parameter logic [7:0] WR_MASK = 8'h8C,
  parameter int         WEL_BIT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_vld,
  input  st_cmd_t    cmd,
  input  logic [7:0] wdata,
  output logic [7:0] stat,
  output logic       wel
);
  localparam logic [7:0] KEEP = WR_MASK & ~(8'd1 << WEL_BIT);

  logic [7:0] bits_q;
  logic       wel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      wel_q  <= 1'b0;
    end else if (cmd_vld) begin
      unique case (cmd)
        ST_SET:  wel_q  <= 1'b1;
        ST_CLR:  wel_q  <= 1'b0;
        ST_WR:   bits_q <= wdata & KEEP;
        default: ;
      endcase
    end
  end

  assign wel  = wel_q;
  assign stat = bits_q | ({7'd0, wel_q} << WEL_BIT);

endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int         ADDR_W    = 11,
  parameter int         SYNC_W    = 2,
  parameter logic [7:0] STAT_MASK = 8'h8C
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int HI_W = ADDR_W - 8;

  logic fe_rise, fe_fall, cs_hi, hold_ok, mosi_s;

  spi_mem_sync #(.SYNC_W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .mosi(mosi),
    .sck_rise(fe_rise), .sck_fall(fe_fall), .cs_hi(cs_hi), .hold_ok(hold_ok),
    .mosi_s(mosi_s)
  );

  logic        st_vld_q;
  st_cmd_t     st_cmd_q;
  logic [7:0]  st_wd_q;
  logic [7:0]  stat;
  logic        wel;

  spi_mem_status #(.WR_MASK(STAT_MASK), .WEL_BIT(1)) u_stat (
    .clk(clk), .rst(rst), .cmd_vld(st_vld_q), .cmd(st_cmd_q), .wdata(st_wd_q),
    .stat(stat), .wel(wel)
  );

  phase_t              phase_q;
  logic                active_q;
  logic [2:0]          bit_q;
  logic [7:0]          shin_q;
  logic [7:0]          shin_nx;
  logic [ADDR_W-1:0]   addr_q;
  logic                hi_done_q;
  logic                is_rd_q;
  logic                wr_seen_q;
  logic [2:0]          ocnt_q;
  logic [7:0]          shout_q;
  logic                started_q;
  logic                oe_q;
  logic                live;
  logic                ram_we;
  logic [7:0]          ram_q;

  assign shin_nx = {shin_q[6:0], mosi_s};
  assign live    = hold_ok && active_q && !cs_hi;
  assign ram_we  = live && fe_rise && (bit_q == 3'd7) && (phase_q == PH_MWR) && wel;

  spi_mem_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
    .clk(clk), .we(ram_we), .addr(addr_q), .wdata(shin_nx), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      active_q  <= 1'b0;
      bit_q     <= '0;
      shin_q    <= '0;
      addr_q    <= '0;
      hi_done_q <= 1'b0;
      is_rd_q   <= 1'b0;
      wr_seen_q <= 1'b0;
      ocnt_q    <= '0;
      shout_q   <= '0;
      started_q <= 1'b0;
      st_vld_q  <= 1'b0;
      st_cmd_q  <= ST_NOP;
      st_wd_q   <= '0;
    end else begin
      st_vld_q <= 1'b0;
      if (hold_ok) begin
        if (!active_q) begin
          if (!cs_hi) begin
            active_q  <= 1'b1;
            phase_q   <= PH_CMD;
            bit_q     <= '0;
            hi_done_q <= 1'b0;
            wr_seen_q <= 1'b0;
            ocnt_q    <= '0;
            started_q <= 1'b0;
          end
        end else if (cs_hi) begin
          active_q  <= 1'b0;
          phase_q   <= PH_IDLE;
          started_q <= 1'b0;
          if (wr_seen_q) begin
            st_vld_q <= 1'b1;
            st_cmd_q <= ST_CLR;
          end
        end else begin
          if (fe_rise) begin
            shin_q <= shin_nx;
            bit_q  <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              unique case (phase_q)
                PH_CMD: begin
                  unique case (shin_nx)
                    CMD_LATCH_SET: begin
                      st_vld_q <= 1'b1;
                      st_cmd_q <= ST_SET;
                      phase_q  <= PH_SKIP;
                    end
                    CMD_LATCH_CLR: begin
                      st_vld_q <= 1'b1;
                      st_cmd_q <= ST_CLR;
                      phase_q  <= PH_SKIP;
                    end
                    CMD_STAT_RD: phase_q <= PH_SRD;
                    CMD_STAT_WR: begin
                      phase_q   <= PH_SWR;
                      wr_seen_q <= 1'b1;
                    end
                    CMD_MEM_RD: begin
                      phase_q <= PH_ADDR;
                      is_rd_q <= 1'b1;
                    end
                    CMD_MEM_WR: begin
                      phase_q   <= PH_ADDR;
                      is_rd_q   <= 1'b0;
                      wr_seen_q <= 1'b1;
                    end
                    default: phase_q <= PH_SKIP;
                  endcase
                end
                PH_ADDR: begin
                  if (!hi_done_q) begin
                    addr_q[ADDR_W-1:8] <= shin_nx[HI_W-1:0];
                    hi_done_q          <= 1'b1;
                  end else begin
                    addr_q[7:0] <= shin_nx;
                    phase_q     <= is_rd_q ? PH_MRD : PH_MWR;
                  end
                end
                PH_MWR: addr_q <= addr_q + 1'b1;
                PH_SWR: begin
                  if (wel) begin
                    st_vld_q <= 1'b1;
                    st_cmd_q <= ST_WR;
                    st_wd_q  <= shin_nx;
                  end
                  phase_q <= PH_SKIP;
                end
                default: ;
              endcase
            end
          end
          if (fe_fall && (phase_q == PH_MRD || phase_q == PH_SRD)) begin
            if (ocnt_q == 3'd0) begin
              shout_q <= (phase_q == PH_MRD) ? ram_q : stat;
              if (phase_q == PH_MRD) addr_q <= addr_q + 1'b1;
            end else begin
              shout_q <= {shout_q[6:0], 1'b0};
            end
            ocnt_q    <= ocnt_q + 3'd1;
            started_q <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= started_q && live;
  end

  assign miso    = shout_q[7];
  assign miso_oe = oe_q;

endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk
  import spi_mem_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    cs_n,
  input logic    hold_n,
  input logic    miso,
  input logic    miso_oe,
  input logic    sck_fall,
  input logic    wel,
  input logic    st_vld,
  input st_cmd_t st_cmd
);

  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

  // R10
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2) && !$past(hold_n, 3)) |-> !miso_oe);

  // R2
  miso_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> $past(sck_fall));

  // R3
  latch_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(st_vld && st_cmd == ST_SET));

  // R8
  latch_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wel) |-> $past(st_vld && st_cmd == ST_CLR));

endmodule

bind spi_mem_slave spi_mem_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .hold_n(hold_n), .miso(miso),
  .miso_oe(miso_oe), .sck_fall(fe_fall), .wel(wel), .st_vld(st_vld_q),
  .st_cmd(st_cmd_q)
);

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic hold_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe;

  spi_mem_slave i_spi_mem_slave (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit cpol = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t expq[$];

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: assemble bytes while the output is enabled, compare with scoreboard
  logic [7:0] mon_sh = 8'h00;
  int         mon_n = 0;
  exp_t       mon_e;
  always @(posedge sck) begin
    if (miso_oe === 1'b1) begin
      mon_sh = {mon_sh[6:0], miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (expq.size() == 0) begin
          check(1'b0, "R6 unexpected byte", mon_sh, 8'h00);
        end else begin
          mon_e = expq.pop_front();
          check(mon_sh === mon_e.val, mon_e.tag, mon_sh, mon_e.val);
        end
      end
    end
  end

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      sck  = 1'b0;
      mosi = d[7-i];
      half();
      sck = 1'b1;
      half();
    end
  endtask

  task automatic xbyte(input logic [7:0] d);
    bits(d, 8);
  endtask

  task automatic begin_f();
    sck = cpol;
    half();
    cs_n = 1'b0;
    half();
  endtask

  task automatic end_f();
    if (!cpol) begin
      sck = 1'b0;
      half();
    end
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic rd_exp(input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    expq.push_back(e);
    xbyte(8'h00);
  endtask

  task automatic cmd_only(input logic [7:0] op);
    begin_f();
    xbyte(op);
    end_f();
  endtask

  task automatic stat_chk(input logic [7:0] v, input string tag);
    begin_f();
    xbyte(8'h05);
    rd_exp(v, tag);
    end_f();
  endtask

  task automatic hdr(input logic [7:0] op, input logic [15:0] a);
    xbyte(op);
    xbyte(a[15:8]);
    xbyte(a[7:0]);
  endtask

  task automatic pause();
    sck = 1'b0;
    half();
    hold_n = 1'b0;
    half();
    check(miso_oe === 1'b0, "R10 oe during hold", {7'd0, miso_oe}, 8'h00);
    for (int k = 0; k < 3; k++) begin
      sck  = 1'b1;
      mosi = ~mosi;
      half();
      sck = 1'b0;
      half();
    end
    cs_n = 1'b1;
    half();
    cs_n = 1'b0;
    half();
    hold_n = 1'b1;
    half();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 8'h00, 8'h01);
      report();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(miso_oe === 1'b0, "R11 reset oe", {7'd0, miso_oe}, 8'h00);

    // reset status and latch set/clear
    stat_chk(8'h00, "R3 reset status");
    cmd_only(8'h06);
    stat_chk(8'h02, "R3 latch set");

    // enabled streaming write, then latch cleared at frame end
    begin_f();
    hdr(8'h02, 16'h0123);
    xbyte(8'h11); xbyte(8'h22); xbyte(8'h33); xbyte(8'h44);
    end_f();
    stat_chk(8'h00, "R8 latch cleared after write");

    // streaming read in mode 3
    cpol = 1'b1;
    begin_f();
    hdr(8'h03, 16'h0123);
    rd_exp(8'h11, "R2 mode3 read b0");
    rd_exp(8'h22, "R6 read b1");
    rd_exp(8'h33, "R6 read b2");
    rd_exp(8'h44, "R6 read b3");
    end_f();
    cpol = 1'b0;
    check(miso_oe === 1'b0, "R11 oe after frame", {7'd0, miso_oe}, 8'h00);

    // write without latch is dropped
    begin_f();
    hdr(8'h02, 16'h0124);
    xbyte(8'h99);
    end_f();
    begin_f();
    hdr(8'h03, 16'h0124);
    rd_exp(8'h22, "R5 write ignored without latch");
    end_f();

    // latch set then cleared
    cmd_only(8'h06);
    cmd_only(8'h04);
    stat_chk(8'h00, "R3 latch cleared by 0x04");

    // status write with latch, masked, repeated readout
    cmd_only(8'h06);
    begin_f();
    xbyte(8'h01);
    xbyte(8'hFF);
    end_f();
    begin_f();
    xbyte(8'h05);
    rd_exp(8'h8C, "R4 status bits stored");
    rd_exp(8'h8C, "R3 status repeats");
    end_f();
    begin_f();
    xbyte(8'h01);
    xbyte(8'h00);
    end_f();
    stat_chk(8'h8C, "R4 status write ignored without latch");

    // wrap across the top, upper address bits ignored
    cmd_only(8'h06);
    begin_f();
    hdr(8'h02, 16'hF7FE);
    xbyte(8'hA1); xbyte(8'hA2); xbyte(8'hA3);
    end_f();
    begin_f();
    hdr(8'h03, 16'h07FE);
    rd_exp(8'hA1, "R5 upper address bits ignored");
    rd_exp(8'hA2, "R7 top address");
    rd_exp(8'hA3, "R7 wrapped to zero");
    end_f();

    // partial final byte discarded
    cmd_only(8'h06);
    begin_f();
    hdr(8'h02, 16'h0200);
    xbyte(8'h00); xbyte(8'h00);
    end_f();
    cmd_only(8'h06);
    begin_f();
    hdr(8'h02, 16'h0200);
    xbyte(8'h5A);
    bits(8'hFF, 4);
    end_f();
    begin_f();
    hdr(8'h03, 16'h0200);
    rd_exp(8'h5A, "R9 full byte kept");
    rd_exp(8'h00, "R9 partial byte dropped");
    end_f();

    // unknown command, then extra bytes after a latch command
    cmd_only(8'h06);
    begin_f();
    xbyte(8'hFF);
    xbyte(8'h04);
    end_f();
    stat_chk(8'h8E, "R1 unknown command ignored");
    begin_f();
    xbyte(8'h06);
    xbyte(8'h04);
    end_f();
    stat_chk(8'h8E, "R12 second command ignored");
    cmd_only(8'h04);
    stat_chk(8'h8C, "R3 latch clear");

    // hold during write and read
    cmd_only(8'h06);
    begin_f();
    hdr(8'h02, 16'h0300);
    bits(8'hC3, 4);
    pause();
    bits(8'h30, 4);
    xbyte(8'hD4);
    end_f();
    begin_f();
    hdr(8'h03, 16'h0300);
    begin
      exp_t e;
      e.val = 8'hC3;
      e.tag = "R10 held write byte";
      expq.push_back(e);
    end
    bits(8'h00, 4);
    check(miso_oe === 1'b1, "R11 oe while shifting", {7'd0, miso_oe}, 8'h01);
    pause();
    bits(8'h00, 4);
    rd_exp(8'hD4, "R10 resume after hold");
    end_f();

    check(expq.size() == 0, "R6 scoreboard drained", 8'(expq.size()), 8'h00);
    done = 1'b1;
    report();
  end

endmodule